// File: doc/BRIEF.md
# Burst Address Generator with Linear and Interleaved Beat Order

This block supplies the word address for every beat of a four-beat burst into a synchronous memory. When a burst starts, it captures the whole external address. After that it walks the two lowest address bits through the four beats of the aligned four-word group. The upper bits stay fixed for the whole burst.

A burst starts when either of two active-low address strobes is sampled low and the chip-enable logic qualifies the start. The beat moves forward only on an active-low advance request that is sampled while both strobes are high. The advance input has no effect on the edge that loads a new address.

A mode pin selects the beat order. The linear order adds the beat count to the start beat, modulo four. The interleaved order XORs the beat count into the start beat. The mode is captured together with the address, so one burst keeps one order. The output comes straight from registers and is valid one clock edge after the inputs that cause it.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the next value of `cur_addr` is 0, the beat count is 0 and the order is linear.
- R2: When `start_ok` is 1 and either `strb_proc_n` or `strb_ctrl_n` is sampled low, `cur_addr` equals the sampled `ext_addr` after that edge.
- R3: When a strobe is sampled low but `start_ok` is 0, nothing is loaded and `cur_addr` holds its value.
- R4: On an edge that loads an address, `adv_n` has no effect. The beat count starts at 0 whatever the value of `adv_n`.
- R5: The beat count increments by one, modulo 4, only when `adv_n` is sampled 0 and both strobes are sampled 1.
- R6: With order 0 (linear) latched, `cur_addr[1:0]` equals (start low bits + beat count) mod 4.
- R7: With order 1 (interleaved) latched, `cur_addr[1:0]` equals start low bits XOR beat count. For example, start 1 gives the order 1,0,3,2.
- R8: `order_sel` is captured only on a load edge. Changing it during a burst does not change `cur_addr`.
- R9: `cur_addr[19:2]` never changes except on a load. Four advances return the address to the start beat.
- R10: With `adv_n` at 1 and both strobes at 1, `cur_addr` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_addr | input | 20 | External word address, captured at burst start |
| strb_proc_n | input | 1 | Active-low processor-side address strobe |
| strb_ctrl_n | input | 1 | Active-low controller-side address strobe |
| adv_n | input | 1 | Active-low beat advance request |
| order_sel | input | 1 | Beat order: 1 interleaved, 0 linear |
| start_ok | input | 1 | Burst-start qualifier from chip-enable logic |
| cur_addr | output | 20 | Address for the current beat |

## Verification
Every result the block produces is due exactly one rising edge after the inputs that cause it, because `cur_addr` is decoded only from registered state. The bench changes inputs on the falling edge. It updates its behavioural model at the next rising edge using those same inputs. It compares `cur_addr` with the model on the falling edge after that, which is the first point where the new registered value is settled. Under every input pattern, each requirement, including the ignored-advance and held-mode cases, therefore comes down to a single comparison one cycle later.

// File: rtl/bag_pkg.sv
// Package: shared types for the burst address generator.
// Assumes a power-of-two burst length expressed in beat-count bits.
package bag_pkg;
    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } beat_order_e;
endpackage

// File: rtl/bag_strobe_qual.sv
// Module: bag_strobe_qual
// Decodes the strobes, the qualifier and the advance request into two
// mutually exclusive commands: load a new address, or step one beat.
// Assumes all inputs are synchronous and sampled at the clock edge.
module bag_strobe_qual (
    input  logic strb_proc_n,
    input  logic strb_ctrl_n,
    input  logic adv_n,
    input  logic start_ok,
    output logic load_o,
    output logic step_o
);
    logic any_strobe;

    // Purpose: form the load and step commands.
    always_comb begin
        any_strobe = !strb_proc_n || !strb_ctrl_n;
        load_o     = start_ok && any_strobe;
        step_o     = !adv_n && !any_strobe;
    end
endmodule

// File: rtl/bag_beat_counter.sv
// Module: bag_beat_counter
// Holds the captured start address, the latched beat order and the
// beat count. A load has priority over a step.
// Assumes load and step come from bag_strobe_qual.
module bag_beat_counter
    import bag_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              order_i,
    output logic [ADDR_W-1:0] base_o,
    output logic [BEAT_W-1:0] beat_o,
    output beat_order_e       order_o
);
    // Purpose: capture the start state on load, otherwise count beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_o  <= '0;
            beat_o  <= '0;
            order_o <= ORD_LINEAR;
        end else if (load_i) begin
            base_o  <= addr_i;
            beat_o  <= '0;
            order_o <= beat_order_e'(order_i);
        end else if (step_i) begin
            beat_o  <= beat_o + BEAT_W'(1);
        end
    end

    // R5: one step moves the beat count by exactly one.
    assert_step_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |=> beat_o == BEAT_W'($past(beat_o) + BEAT_W'(1)));

    // R4: a load restarts the beat count regardless of the advance request.
    assert_load_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> beat_o == '0);

    // R8: the order changes only on a load.
    assert_order_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(order_o));
endmodule

// File: rtl/bag_beat_map.sv
// Module: bag_beat_map
// Maps the start address and beat count to the current beat address.
// Both beat orders are built, and the latched order picks one.
// Assumes the burst length is 2**BEAT_W and the burst is aligned to it.
module bag_beat_map
    import bag_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [BEAT_W-1:0] beat_i,
    input  beat_order_e       order_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int HI_W = ADDR_W - BEAT_W;

    logic [BEAT_W-1:0] lin_lo;
    logic [BEAT_W-1:0] ilv_lo;

    // Purpose: linear order, add the beat count with wrap in the group.
    always_comb lin_lo = base_i[BEAT_W-1:0] + beat_i;

    // Purpose: interleaved order, one XOR per beat bit.
    for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
        assign ilv_lo[b] = base_i[b] ^ beat_i[b];
    end

    // Purpose: keep the group bits and select the order for the beat bits.
    always_comb begin
        addr_o[ADDR_W-1:BEAT_W] = base_i[ADDR_W-1:BEAT_W];
        addr_o[BEAT_W-1:0]      = (order_i == ORD_INTERLEAVE) ? ilv_lo : lin_lo;
    end

    // R9: a zero beat count always gives back the start address.
    always_comb begin
        if (beat_i == '0) begin
            assert_start_beat_R9: assert (addr_o == base_i || $isunknown(base_i));
        end
    end

    if (HI_W < 1) begin : g_bad_width
        initial $error("bag_beat_map: ADDR_W must exceed BEAT_W");
    end
endmodule

// File: rtl/burst_addr_gen.sv
// Module: burst_addr_gen (top)
// Address generator for a four-beat memory burst. It loads on a qualified
// strobe and steps on a qualified advance, in linear or interleaved order.
// Assumes synchronous inputs and a synchronous active-low reset.
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int BEAT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              strb_proc_n,
    input  logic              strb_ctrl_n,
    input  logic              adv_n,
    input  logic              order_sel,
    input  logic              start_ok,
    output logic [ADDR_W-1:0] cur_addr
);
    logic              load_w;
    logic              step_w;
    logic [ADDR_W-1:0] base_w;
    logic [BEAT_W-1:0] beat_w;
    beat_order_e       order_w;

    bag_strobe_qual u_qual (
        .strb_proc_n (strb_proc_n),
        .strb_ctrl_n (strb_ctrl_n),
        .adv_n       (adv_n),
        .start_ok    (start_ok),
        .load_o      (load_w),
        .step_o      (step_w)
    );

    bag_beat_counter #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_w),
        .step_i  (step_w),
        .addr_i  (ext_addr),
        .order_i (order_sel),
        .base_o  (base_w),
        .beat_o  (beat_w),
        .order_o (order_w)
    );

    bag_beat_map #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_map (
        .base_i  (base_w),
        .beat_i  (beat_w),
        .order_i (order_w),
        .addr_o  (cur_addr)
    );

    // R1: reset drives the address to zero.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> cur_addr == '0);

    // R2: a qualified strobe loads the external address.
    assert_load_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ok && (!strb_proc_n || !strb_ctrl_n)) |=> cur_addr == $past(ext_addr));

    // R3: a strobe without the qualifier changes nothing.
    assert_unqualified_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_ok && (!strb_proc_n || !strb_ctrl_n)) |=> $stable(cur_addr));

    // R10: no strobe and no advance holds the address.
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_n && strb_proc_n && strb_ctrl_n) |=> $stable(cur_addr));

    // R9: the group bits are fixed outside a load.
    assert_group_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_ok && (!strb_proc_n || !strb_ctrl_n))
        |=> $stable(cur_addr[ADDR_W-1:BEAT_W]));
endmodule

// File: tb/burst_addr_gen_tb_top.sv
// Bench: behavioural reference model, compared against cur_addr every cycle.
module burst_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [19:0] ext_addr;
    logic        strb_proc_n, strb_ctrl_n, adv_n, order_sel, start_ok;
    logic [19:0] cur_addr;

    int tests  = 0;
    int fails  = 0;
    int cycles = 0;

    // model state
    int m_base = 0;
    int m_beat = 0;
    int m_ilv  = 0;

    always #4 clk = ~clk;

    burst_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
        .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n),
        .adv_n(adv_n), .order_sel(order_sel), .start_ok(start_ok),
        .cur_addr(cur_addr)
    );

    function automatic int model_addr();
        int lo;
        lo = (m_ilv != 0) ? ((m_base & 3) ^ m_beat) : (((m_base & 3) + m_beat) % 4);
        return (m_base & 32'hFFFFC) | lo;
    endfunction

    // One cycle: drive at negedge, update the model at posedge, compare at the next negedge.
    task automatic step(input logic r, input logic [19:0] a, input logic p, input logic c,
                        input logic v, input logic o, input logic q, input string tag);
        int exp;
        rst_n = r; ext_addr = a; strb_proc_n = p; strb_ctrl_n = c;
        adv_n = v; order_sel = o; start_ok = q;
        @(posedge clk);
        if (!r) begin
            m_base = 0; m_beat = 0; m_ilv = 0;
        end else if (q && (!p || !c)) begin
            m_base = int'(a); m_beat = 0; m_ilv = int'(o);
        end else if (!v && p && c) begin
            m_beat = (m_beat + 1) % 4;
        end
        @(negedge clk);
        exp = model_addr();
        tests++;
        if (int'(cur_addr) != exp) begin
            fails++;
            $display("FAIL %s: cur_addr=%05h expected=%05h", tag, cur_addr, exp[19:0]);
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: cycles=%0d expected<=%0d", cycles, 20000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        step(0, 20'hABCDE, 0, 1, 0, 1, 1, "R1");
        step(0, 20'h00000, 1, 1, 1, 0, 0, "R1");
        // R2: load on processor strobe, then controller strobe
        step(1, 20'h12345, 0, 1, 1, 0, 1, "R2");
        step(1, 20'h54322, 1, 0, 1, 0, 1, "R2");
        // R3: unqualified strobe ignored
        step(1, 20'hFFFFF, 0, 0, 0, 1, 0, "R3");
        // R10: idle holds
        step(1, 20'h0F0F0, 1, 1, 1, 1, 1, "R10");
        // R4: advance low on load edge ignored
        step(1, 20'h00AA9, 0, 1, 0, 0, 1, "R4");
        // R5/R6: linear from start 1 -> 2,3,0,1 (R9 wrap)
        for (int i = 0; i < 4; i++) step(1, 20'h0, 1, 1, 0, 1, 1, (i == 3) ? "R9" : "R6");
        // R5: advance blocked while a strobe is low and unqualified
        step(1, 20'h77777, 1, 0, 0, 0, 0, "R5");
        // R7: interleaved start 1 -> 0,3,2,1
        step(1, 20'h3C001, 1, 0, 0, 1, 1, "R4");
        for (int i = 0; i < 4; i++) step(1, 20'h0, 1, 1, 0, 0, 1, (i == 3) ? "R9" : "R7");
        // R8: order change mid-burst, then the remaining interleaved beats
        step(1, 20'h8F002, 0, 1, 1, 1, 1, "R2");
        step(1, 20'h0, 1, 1, 0, 0, 1, "R8");
        step(1, 20'h0, 1, 1, 1, 0, 1, "R8");
        step(1, 20'h0, 1, 1, 0, 0, 1, "R8");
        // R7/R6: every start beat in both orders
        for (int s = 0; s < 4; s++) begin
            for (int o = 0; o < 2; o++) begin
                step(1, 20'(32'h5A5A4 | s), 0, 0, 0, o[0], 1, "R2");
                for (int k = 0; k < 4; k++)
                    step(1, 20'h0, 1, 1, 0, 1'b0, 1, (o == 1) ? "R7" : "R6");
            end
        end
        // R1: reset in mid-burst
        step(0, 20'h0, 1, 1, 0, 0, 1, "R1");
        step(1, 20'h0, 1, 1, 0, 0, 1, "R5");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule